// File: doc/BRIEF.md
# Zero-Suppressed Event Readout Serializer

This block drains a front-end chip's event memory at the end of an acquisition and sends it out as a stream of 16-bit words on one serial data line, most significant bit first, with a valid strobe that is high for every bit. A readout begins on a start pulse. The chip identifier goes first, inside a header word. Each stored event follows, as one word that holds its bunch-crossing ID and encoded data, then one word for every channel that recorded a hit in that event. Channels without a hit produce no word. The block reads the memory through a combinational port: it presents an event index and gets back that event's bunch-crossing ID, its encoded data and its hit-channel bitmap in the same cycle.

Each word puts a type flag in bit 15 and an even-parity bit in bit 14, and uses bits 13..0 as payload. A configuration input decides what happens when the memory holds no event: either nothing is sent, or the header word alone is sent. In both cases the block signals completion with a one-cycle done pulse.

Top module: `zs_readout_ser`

## Requirements
- R1: After reset, sdo_o, sdo_valid_o and done_o are all 0.
- R2: The first word of every readout is the header {1, parity, 6'b111111, chip_id[7:0]}. Its MSB appears on sdo_o with sdo_valid_o high in the second cycle after the clock edge that samples start_i.
- R3: Each word goes out MSB first, one bit per cycle. Words follow one another with no idle cycle, and sdo_valid_o stays high for every bit of the readout.
- R4: For each event index e from 0 to nevt_i-1 in ascending order, a bunch-crossing word {0, parity, bcid[11:0], enc[1:0]} is sent, where bcid and enc are read at mem_addr_o = e.
- R5: After its bunch-crossing word, each event sends one hit word {1, parity, channel[5:0], e[7:0]} for every bit set in its hit bitmap, in ascending channel order. Cleared bits produce no word.
- R6: Bit 14 of every word is the XOR of the other 15 bits, so every word carries an even number of ones.
- R7: done_o is high for exactly one cycle, the cycle right after the last bit. sdo_o is 0 whenever sdo_valid_o is 0.
- R8: When nevt_i is 0 and arcid_i is 0, no bit is sent, and done_o pulses in the first cycle after the edge that samples start_i.
- R9: When nevt_i is 0 and arcid_i is 1, exactly the header word is sent.
- R10: A start_i pulse that arrives while a readout is in progress does not change the stream.
- R11: An event whose hit bitmap is all zero sends only its bunch-crossing word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Readout start pulse; taken only when idle |
| arcid_i | input | 1 | 1: send the header even when no event is stored |
| chip_id_i | input | 8 | Chip identifier placed in the header |
| nevt_i | input | 8 | Number of stored events, sampled at start |
| mem_addr_o | output | 8 | Event index presented to the memory |
| mem_bcid_i | input | 12 | Bunch-crossing ID of the addressed event |
| mem_enc_i | input | 2 | Encoded data of the addressed event |
| mem_hits_i | input | 32 | Hit-channel bitmap of the addressed event |
| sdo_o | output | 1 | Serial data, MSB first |
| sdo_valid_o | output | 1 | High for every transmitted bit |
| done_o | output | 1 | One-cycle pulse at the end of a readout |

## Verification
There is one register between the edge that samples start and the word loader, and one more before the shifter output, so the header MSB is due two cycles after that edge. Bit i of word k then falls in cycle 2+16k+i, and done is due in cycle 2+16W for a readout of W words. The bench drives start on a falling edge and samples every output on the falling edges that follow. It counts cycles from the start edge and compares each assembled word, plus the done cycle, against that fixed schedule. The empty readout without the header has its done pulse one cycle after the start edge, and the bench checks that cycle directly.

// File: rtl/zs_pkg.sv
package zs_pkg;

   localparam int WORD_W = 16;
   localparam int PAY_W  = WORD_W - 2;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_HDR,
      SQ_BCID,
      SQ_HITS,
      SQ_END
   } zs_state_e;

   // type flag on top, even parity below it, payload underneath
   function automatic logic [WORD_W-1:0] seal_word(input logic kind,
                                                   input logic [PAY_W-1:0] pay);
      return {kind, kind ^ (^pay), pay};
   endfunction

endpackage

// File: rtl/zs_hit_scan.sv
module zs_hit_scan #(
   parameter int NCH       = 32,
   parameter int IDX_W     = 6,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic [NCH-1:0]   mask_i,
   output logic             found_o,
   output logic [IDX_W-1:0] idx_o
);

   assign found_o = |mask_i;

   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            idx_o = '0;
            for (int i = NCH - 1; i >= 0; i--) begin
               if (mask_i[i]) idx_o = IDX_W'(i);
            end
         end
      end else begin : g_high
         always_comb begin
            idx_o = '0;
            for (int i = 0; i < NCH; i++) begin
               if (mask_i[i]) idx_o = IDX_W'(i);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/zs_shifter.sv
module zs_shifter #(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              avail_i,
   output logic              take_o,
   output logic              sdo_o,
   output logic              busy_o
);

   localparam int CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

   logic [WORD_W-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic              busy_q;

   assign take_o = avail_i && (!busy_q || cnt_q == LAST);
   assign sdo_o  = busy_q & sh_q[WORD_W-1];
   assign busy_o = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (take_o) begin
         sh_q   <= word_i;
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
            sh_q   <= '0;
         end else begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // every loaded word has even weight
   assert_even_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (^word_i) == 1'b0);

   // no bubble inside a word
   assert_word_contiguous_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && cnt_q != LAST) |=> busy_q);

endmodule

// File: rtl/zs_word_seq.sv
module zs_word_seq
   import zs_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int EVT_W     = 8,
   parameter int ENC_W     = 2,
   parameter bit LOW_FIRST = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     arcid_i,
   input  logic [EVT_W-1:0]         chip_id_i,
   input  logic [EVT_W-1:0]         nevt_i,
   output logic [EVT_W-1:0]         mem_addr_o,
   input  logic [PAY_W-ENC_W-1:0]   mem_bcid_i,
   input  logic [ENC_W-1:0]         mem_enc_i,
   input  logic [NCH-1:0]           mem_hits_i,
   input  logic                     take_i,
   input  logic                     sh_busy_i,
   output logic [WORD_W-1:0]        word_o,
   output logic                     avail_o,
   output logic                     done_o
);

   localparam int CH_W = PAY_W - EVT_W;
   localparam logic [CH_W-1:0] HDR_MARK = '1;

   zs_state_e        state_q, state_d;
   logic [EVT_W-1:0] evt_q, evt_d;
   logic [EVT_W-1:0] nevt_q, nevt_d;
   logic [NCH-1:0]   mask_q, mask_d;
   logic [NCH-1:0]   mask_next;
   logic             hit_found;
   logic [CH_W-1:0]  hit_idx;
   logic             last_evt;

   zs_hit_scan #(.NCH(NCH), .IDX_W(CH_W), .LOW_FIRST(LOW_FIRST)) scan_i (
      .mask_i  (mask_q),
      .found_o (hit_found),
      .idx_o   (hit_idx)
   );

   assign mask_next  = mask_q & ~(NCH'(1) << hit_idx);
   assign last_evt   = (evt_q == nevt_q - EVT_W'(1));
   assign mem_addr_o = evt_q;
   assign done_o     = (state_q == SQ_END) && !sh_busy_i;

   always_comb begin
      unique case (state_q)
         SQ_HDR:  word_o = seal_word(1'b1, {HDR_MARK, chip_id_i});
         SQ_BCID: word_o = seal_word(1'b0, {mem_bcid_i, mem_enc_i});
         SQ_HITS: word_o = seal_word(1'b1, {hit_idx, evt_q});
         default: word_o = '0;
      endcase
   end

   assign avail_o = (state_q == SQ_HDR) || (state_q == SQ_BCID) || (state_q == SQ_HITS);

   always_comb begin
      state_d = state_q;
      evt_d   = evt_q;
      nevt_d  = nevt_q;
      mask_d  = mask_q;
      unique case (state_q)
         SQ_IDLE: if (start_i) begin
            evt_d   = '0;
            nevt_d  = nevt_i;
            state_d = (nevt_i == '0 && !arcid_i) ? SQ_END : SQ_HDR;
         end
         SQ_HDR: if (take_i) begin
            state_d = (nevt_q == '0) ? SQ_END : SQ_BCID;
         end
         SQ_BCID: if (take_i) begin
            if (mem_hits_i != '0) begin
               mask_d  = mem_hits_i;
               state_d = SQ_HITS;
            end else if (last_evt) begin
               state_d = SQ_END;
            end else begin
               evt_d = evt_q + 1'b1;
            end
         end
         SQ_HITS: if (take_i) begin
            mask_d = mask_next;
            if (mask_next == '0) begin
               if (last_evt) state_d = SQ_END;
               else begin
                  evt_d   = evt_q + 1'b1;
                  state_d = SQ_BCID;
               end
            end
         end
         SQ_END: if (!sh_busy_i) state_d = SQ_IDLE;
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         evt_q   <= '0;
         nevt_q  <= '0;
         mask_q  <= '0;
      end else begin
         state_q <= state_d;
         evt_q   <= evt_d;
         nevt_q  <= nevt_d;
         mask_q  <= mask_d;
      end
   end

   // the header is only ever loaded into an empty shifter, so it leads
   assert_header_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_HDR) |-> !sh_busy_i);

   // hit words are typed 1 and only exist while a hit remains
   assert_hit_word_typed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_HITS) |-> (word_o[WORD_W-1] && hit_found));

   // empty memory without header option: straight to completion
   assert_empty_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && start_i && nevt_i == '0 && !arcid_i)
         |=> (done_o && !sh_busy_i));

endmodule

// File: rtl/zs_readout_ser.sv
module zs_readout_ser
   import zs_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int EVT_W     = 8,
   parameter int ENC_W     = 2,
   parameter bit LOW_FIRST = 1'b1,
   localparam int CH_W     = PAY_W - EVT_W,
   localparam int BCID_W   = PAY_W - ENC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              arcid_i,
   input  logic [EVT_W-1:0]  chip_id_i,
   input  logic [EVT_W-1:0]  nevt_i,
   output logic [EVT_W-1:0]  mem_addr_o,
   input  logic [BCID_W-1:0] mem_bcid_i,
   input  logic [ENC_W-1:0]  mem_enc_i,
   input  logic [NCH-1:0]    mem_hits_i,
   output logic              sdo_o,
   output logic              sdo_valid_o,
   output logic              done_o
);

   generate
      if (CH_W < 1 || NCH >= (1 << CH_W)) begin : g_bad_nch
         $error("zs_readout_ser: NCH must fit below the all-ones header marker");
      end
      if (ENC_W < 1 || ENC_W >= PAY_W) begin : g_bad_enc
         $error("zs_readout_ser: ENC_W out of range");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   logic              avail;
   logic              take;
   logic              sh_busy;

   zs_word_seq #(
      .NCH(NCH), .EVT_W(EVT_W), .ENC_W(ENC_W), .LOW_FIRST(LOW_FIRST)
   ) seq_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .arcid_i    (arcid_i),
      .chip_id_i  (chip_id_i),
      .nevt_i     (nevt_i),
      .mem_addr_o (mem_addr_o),
      .mem_bcid_i (mem_bcid_i),
      .mem_enc_i  (mem_enc_i),
      .mem_hits_i (mem_hits_i),
      .take_i     (take),
      .sh_busy_i  (sh_busy),
      .word_o     (word),
      .avail_o    (avail),
      .done_o     (done_o)
   );

   zs_shifter #(.WORD_W(WORD_W)) shf_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .word_i  (word),
      .avail_i (avail),
      .take_o  (take),
      .sdo_o   (sdo_o),
      .busy_o  (sh_busy)
   );

   assign sdo_valid_o = sh_busy;

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_done_no_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !sdo_valid_o);

endmodule

// File: tb/zs_readout_ser_tb_top.sv
`timescale 1ns/1ps
module zs_readout_ser_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        arcid = 1'b0;
   logic [7:0]  chip_id = 8'hA5;
   logic [7:0]  nevt = 8'd0;
   logic [7:0]  mem_addr;
   logic [11:0] mem_bcid;
   logic [1:0]  mem_enc;
   logic [31:0] mem_hits;
   logic        sdo, sdo_valid, done;

   logic [11:0] m_bcid [0:7];
   logic [1:0]  m_enc  [0:7];
   logic [31:0] m_hits [0:7];

   logic [15:0] exp_w [0:127];
   int          exp_n;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   assign mem_bcid = m_bcid[mem_addr[2:0]];
   assign mem_enc  = m_enc[mem_addr[2:0]];
   assign mem_hits = m_hits[mem_addr[2:0]];

   zs_readout_ser dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .arcid_i(arcid),
      .chip_id_i(chip_id), .nevt_i(nevt), .mem_addr_o(mem_addr),
      .mem_bcid_i(mem_bcid), .mem_enc_i(mem_enc), .mem_hits_i(mem_hits),
      .sdo_o(sdo), .sdo_valid_o(sdo_valid), .done_o(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // even parity: bit 14 makes the whole word XOR to zero
   function automatic logic [15:0] mk(input logic t, input logic [13:0] p);
      logic par;
      par = t;
      for (int i = 0; i < 14; i++) par = par ^ p[i];
      return {t, par, p};
   endfunction

   task automatic build(input int nev, input bit arc);
      exp_n = 0;
      if (nev == 0 && !arc) return;
      exp_w[exp_n++] = mk(1'b1, {6'h3F, chip_id});
      for (int e = 0; e < nev; e++) begin
         exp_w[exp_n++] = mk(1'b0, {m_bcid[e], m_enc[e]});
         for (int c = 0; c < 32; c++)
            if (m_hits[e][c]) exp_w[exp_n++] = mk(1'b1, {c[5:0], e[7:0]});
      end
   endtask

   task automatic run_rd(input int nev, input bit arc, input bit poke, input string tag);
      logic [15:0] got;
      bit          vok;
      build(nev, arc);
      @(negedge clk);
      nevt = nev[7:0]; arcid = arc; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (exp_n == 0) begin
         chk(done && !sdo_valid, {tag, " R8 done one cycle after start"}, done, 1);
         vok = 1;
         for (int k = 0; k < 24; k++) begin
            @(negedge clk);
            if (sdo_valid || done || sdo) vok = 0;
         end
         chk(vok, {tag, " R8 no bit sent"}, vok, 1);
         return;
      end
      chk(!sdo_valid && !done, {tag, " R2 nothing in first cycle"}, sdo_valid, 0);
      for (int w = 0; w < exp_n; w++) begin
         got = '0; vok = 1;
         for (int b = 0; b < 16; b++) begin
            @(negedge clk);
            if (poke && w == 1 && b == 3) start = 1'b1;
            if (poke && w == 1 && b == 4) start = 1'b0;
            got = {got[14:0], sdo};
            if (!sdo_valid || done) vok = 0;
         end
         chk(got == exp_w[w], $sformatf("%s R4/R5/R6/R9/R11 word %0d", tag, w), got, exp_w[w]);
         chk(vok, $sformatf("%s R3 valid during word %0d", tag, w), vok, 1);
      end
      @(negedge clk);
      chk(done && !sdo_valid && !sdo, {tag, " R7 done after last bit"}, done, 1);
      @(negedge clk);
      chk(!done && !sdo_valid && !sdo, {tag, " R7 single done, R10 no restart"}, done, 0);
   endtask

   initial begin : watchdog
      #(20 * 20000);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_bcid[i] = 12'h100 + 12'(i * 37);
         m_enc[i]  = 2'(i);
         m_hits[i] = '0;
      end
      repeat (3) @(negedge clk);
      chk(!sdo && !sdo_valid && !done, "R1 reset outputs", {sdo, sdo_valid, done}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!sdo && !sdo_valid && !done, "R1 idle after reset", {sdo, sdo_valid, done}, 0);

      run_rd(0, 1'b0, 1'b0, "empty_silent");           // R8
      run_rd(0, 1'b1, 1'b0, "empty_header");           // R9, R2
      m_hits[0] = (32'd1 << 3) | (32'd1 << 20);
      run_rd(1, 1'b0, 1'b0, "one_event");              // R4, R5
      chip_id = 8'h3C;
      m_hits[0] = 32'h8000_0001;
      m_hits[1] = '0;
      m_hits[2] = 32'h0000_0F00;
      run_rd(3, 1'b1, 1'b0, "three_events");           // R11, R5 ordering
      m_hits[1] = 32'h0001_0000;
      run_rd(2, 1'b0, 1'b1, "start_mid_readout");      // R10

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule